// File: doc/BRIEF.md
# Latency Allowance Scaling Unit

This unit sits beside the request FIFO of a single memory client. It turns the client's programmed latency allowance (one unit per 30 ns tick) into the effective allowance that the arbiter applies to the request at the FIFO head. While scaling is switched on, the allowance shrinks as the FIFO empties. The fraction of the FIFO that is free is placed in one of four bands by three percentage thresholds. From the lowest band to the highest, the allowance is kept, halved, quartered or forced to zero, so a client whose FIFO is nearly empty gets top urgency.

The three thresholds and the scaling switch are loaded through a small write port. A threshold write with a value above 100 is refused. The unit also reports each threshold as an absolute allowance value, which is the percentage applied to the programmed allowance. When a new request reaches the FIFO head, a countdown loads the current effective allowance. It then counts down once per tick and flags expiry at zero.

Top module: `la_scale_unit`

## Requirements
- R1: After reset all thresholds are 0, scaling is off (so `eff_la` equals `prog_la`), the absolute thresholds read 0, `la_count` is 0 and `la_expired` is low.
- R2: A write selects its target with `cfg_sel`: 0 is the low threshold, 1 the mid threshold, 2 the high threshold and 3 the control byte. A threshold write with `cfg_data` up to 100 is stored at the clock edge. A threshold write above 100 leaves the stored value unchanged.
- R3: Each absolute threshold output equals threshold × `prog_la` / 100, with the fraction truncated.
- R4: Scaling is on only while bit 7 of the last control byte written is 1. While scaling is off, `eff_la` equals `prog_la`.
- R5: With scaling on and free space below the low threshold (`fifo_free`×100 < low×`fifo_depth`), `eff_la` equals `prog_la`.
- R6: With scaling on, free space at or above the low threshold but below the mid threshold gives `eff_la` = `prog_la` >> 1.
- R7: With scaling on, free space at or above the mid threshold but below the high threshold gives `eff_la` = `prog_la` >> 2.
- R8: With scaling on, free space at or above the high threshold gives `eff_la` = 0. Where thresholds overlap, the higher band wins.
- R9: A `head_new` pulse loads `la_count` with the `eff_la` of that cycle. This happens even while a countdown is running.
- R10: After a load, each cycle with `tick` high lowers `la_count` by 1 until it reaches 0, where it stays. `la_expired` is high exactly when a loaded countdown sits at 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 low, 1 mid, 2 high, 3 control |
| cfg_data | input | 8 | Write data (percentage, or control byte with enable in bit 7) |
| prog_la | input | 8 | Programmed latency allowance in ticks |
| fifo_free | input | FREE_W | Free entries in the client FIFO |
| fifo_depth | input | FREE_W | Total FIFO entries |
| head_new | input | 1 | A new request has reached the FIFO head |
| tick | input | 1 | One-cycle strobe per 30 ns allowance tick |
| eff_la | output | 8 | Effective latency allowance |
| thr_abs_lo | output | 8 | Low threshold as an absolute allowance value |
| thr_abs_mid | output | 8 | Mid threshold as an absolute allowance value |
| thr_abs_hi | output | 8 | High threshold as an absolute allowance value |
| la_count | output | 8 | Remaining allowance of the head request |
| la_expired | output | 1 | Head request allowance has run out |

## Verification
The hardest cases to reach are free-space levels that sit exactly on a band boundary. At these levels `fifo_free`×100 equals a threshold times `fifo_depth`, and the inclusive lower bound decides the band. Random depths and free counts almost never land there. The stimulus therefore sets the boundaries directly, with a depth of 100 and also a depth of 40 where 8 free entries is exactly 20 %. It then mixes in random threshold writes, some above 100, that move the boundaries under random free and depth values. The countdown is reloaded in the middle of a count, which checks that a new head request overrides a countdown still in progress.

// File: rtl/la_scale_pkg.sv
package la_scale_pkg;

  localparam int unsigned LA_W    = 8;
  localparam int unsigned PCT_W   = 8;
  localparam int unsigned PCT_MAX = 100;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned N_THR   = 3;

  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_MID = 2'd1,
    SEL_HI  = 2'd2,
    SEL_CTL = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    BAND_FULL = 2'd0,
    BAND_HALF = 2'd1,
    BAND_QTR  = 2'd2,
    BAND_ZERO = 2'd3
  } band_e;

  // percentage of an allowance, truncated
  function automatic logic [LA_W-1:0] pct_of(input logic [PCT_W-1:0] pct,
                                             input logic [LA_W-1:0] la);
    logic [PCT_W+LA_W-1:0] prod;
    prod = (PCT_W+LA_W)'(pct) * (PCT_W+LA_W)'(la);
    return LA_W'(prod / (PCT_W+LA_W)'(PCT_MAX));
  endfunction

  // allowance after band scaling
  function automatic logic [LA_W-1:0] scale_la(input band_e b,
                                               input logic [LA_W-1:0] la);
    case (b)
      BAND_FULL: return la;
      BAND_HALF: return la >> 1;
      BAND_QTR:  return la >> 2;
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/la_thr_regs.sv
module la_thr_regs
  import la_scale_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [1:0]                  cfg_sel,
  input  logic [PCT_W-1:0]            cfg_data,
  output logic [N_THR-1:0][PCT_W-1:0] thr_pct,
  output logic                        scale_on
);

  logic pct_ok;
  assign pct_ok = (cfg_data <= PCT_W'(PCT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_pct  <= '0;
      scale_on <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_sel == SEL_CTL) begin
        scale_on <= cfg_data[EN_BIT];
      end else if (pct_ok) begin
        for (int i = 0; i < int'(N_THR); i++) begin
          if (cfg_sel == 2'(i)) thr_pct[i] <= cfg_data;
        end
      end
    end
  end

endmodule

// File: rtl/la_band_sel.sv
module la_band_sel
  import la_scale_pkg::*;
#(
  parameter int unsigned FREE_W = 8
) (
  input  logic [FREE_W-1:0]           fifo_free,
  input  logic [FREE_W-1:0]           fifo_depth,
  input  logic [N_THR-1:0][PCT_W-1:0] thr_pct,
  output band_e                       band
);

  localparam int unsigned PROD_W = FREE_W + PCT_W;

  logic [PROD_W-1:0] free_x100;
  logic [N_THR-1:0]  at_or_above;

  assign free_x100 = PROD_W'(fifo_free) * PROD_W'(PCT_MAX);

  for (genvar g = 0; g < int'(N_THR); g++) begin : g_cmp
    logic [PROD_W-1:0] thr_x_depth;
    assign thr_x_depth    = PROD_W'(thr_pct[g]) * PROD_W'(fifo_depth);
    assign at_or_above[g] = (free_x100 >= thr_x_depth);
  end

  always_comb begin
    if (at_or_above[2])      band = BAND_ZERO;
    else if (at_or_above[1]) band = BAND_QTR;
    else if (at_or_above[0]) band = BAND_HALF;
    else                     band = BAND_FULL;
  end

endmodule

// File: rtl/la_countdown.sv
module la_countdown
  import la_scale_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            tick,
  input  logic [LA_W-1:0] load_val,
  output logic [LA_W-1:0] cnt,
  output logic            busy,
  output logic            expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (busy && tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = busy && (cnt == '0);

endmodule

// File: rtl/la_scale_unit.sv
module la_scale_unit
  import la_scale_pkg::*;
#(
  parameter int unsigned FREE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [PCT_W-1:0]  cfg_data,
  input  logic [LA_W-1:0]   prog_la,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic [FREE_W-1:0] fifo_depth,
  input  logic              head_new,
  input  logic              tick,
  output logic [LA_W-1:0]   eff_la,
  output logic [LA_W-1:0]   thr_abs_lo,
  output logic [LA_W-1:0]   thr_abs_mid,
  output logic [LA_W-1:0]   thr_abs_hi,
  output logic [LA_W-1:0]   la_count,
  output logic              la_expired
);

  logic [N_THR-1:0][PCT_W-1:0] thr_pct;
  logic [PCT_W-1:0]            thr_pct_lo, thr_pct_mid, thr_pct_hi;
  logic                        scale_on;
  band_e                       band;
  logic                        cd_busy;

  la_thr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .thr_pct  (thr_pct),
    .scale_on (scale_on)
  );

  assign thr_pct_lo  = thr_pct[0];
  assign thr_pct_mid = thr_pct[1];
  assign thr_pct_hi  = thr_pct[2];

  la_band_sel #(.FREE_W(FREE_W)) u_band (
    .fifo_free  (fifo_free),
    .fifo_depth (fifo_depth),
    .thr_pct    (thr_pct),
    .band       (band)
  );

  assign eff_la = scale_on ? scale_la(band, prog_la) : prog_la;

  assign thr_abs_lo  = pct_of(thr_pct_lo,  prog_la);
  assign thr_abs_mid = pct_of(thr_pct_mid, prog_la);
  assign thr_abs_hi  = pct_of(thr_pct_hi,  prog_la);

  la_countdown u_cd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (head_new),
    .tick     (tick),
    .load_val (eff_la),
    .cnt      (la_count),
    .busy     (cd_busy),
    .expired  (la_expired)
  );

endmodule

// File: rtl/la_scale_unit_chk.sv
module la_scale_unit_chk
  import la_scale_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [1:0]      cfg_sel,
  input logic [PCT_W-1:0] cfg_data,
  input logic [LA_W-1:0] prog_la,
  input logic [LA_W-1:0] eff_la,
  input logic [LA_W-1:0] thr_abs_lo,
  input logic [PCT_W-1:0] thr_pct_lo,
  input logic [PCT_W-1:0] thr_pct_mid,
  input logic [PCT_W-1:0] thr_pct_hi,
  input logic            scale_on,
  input logic [1:0]      band,
  input logic            head_new,
  input logic            tick,
  input logic [LA_W-1:0] la_count,
  input logic            cd_busy,
  input logic            la_expired
);

  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel != SEL_CTL && cfg_data > PCT_W'(PCT_MAX)) |=>
      ($stable(thr_pct_lo) && $stable(thr_pct_mid) && $stable(thr_pct_hi)));

  assert_abs_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_abs_lo <= prog_la);

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !scale_on |-> eff_la == prog_la);

  assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_on && band == BAND_ZERO) |-> eff_la == '0);

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    head_new |=> la_count == $past(eff_la));

  assert_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_busy && tick && !head_new && la_count != '0) |=>
      la_count == $past(la_count) - 1'b1);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !head_new) |=> $stable(la_count));

  assert_expired_R10: assert property (@(posedge clk) disable iff (!rst_n)
    la_expired |-> (la_count == '0 && cd_busy));

endmodule

bind la_scale_unit la_scale_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_sel     (cfg_sel),
  .cfg_data    (cfg_data),
  .prog_la     (prog_la),
  .eff_la      (eff_la),
  .thr_abs_lo  (thr_abs_lo),
  .thr_pct_lo  (thr_pct_lo),
  .thr_pct_mid (thr_pct_mid),
  .thr_pct_hi  (thr_pct_hi),
  .scale_on    (scale_on),
  .band        (band),
  .head_new    (head_new),
  .tick        (tick),
  .la_count    (la_count),
  .cd_busy     (cd_busy),
  .la_expired  (la_expired)
);

// File: tb/la_scale_unit_bench.sv
module la_scale_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_data = 8'd0;
  logic [7:0] prog_la = 8'd0;
  logic [7:0] fifo_free = 8'd0;
  logic [7:0] fifo_depth = 8'd1;
  logic       head_new = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] eff_la, thr_abs_lo, thr_abs_mid, thr_abs_hi, la_count;
  logic       la_expired;

  always #10 clk = ~clk;

  la_scale_unit u_la_scale_unit (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .prog_la(prog_la), .fifo_free(fifo_free),
    .fifo_depth(fifo_depth), .head_new(head_new), .tick(tick),
    .eff_la(eff_la), .thr_abs_lo(thr_abs_lo), .thr_abs_mid(thr_abs_mid),
    .thr_abs_hi(thr_abs_hi), .la_count(la_count), .la_expired(la_expired)
  );

  int n_checks = 0;
  int n_fail = 0;
  int m_thr [3] = '{0, 0, 0};
  bit m_en = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int free_pct(input int fr, input int dp);
    return (fr * 100) / dp;
  endfunction

  function automatic int exp_eff(input int la, input int fr, input int dp);
    int p;
    if (!m_en) return la;
    p = free_pct(fr, dp);
    if (p >= m_thr[2]) return 0;
    if (p >= m_thr[1]) return la / 4;
    if (p >= m_thr[0]) return la / 2;
    return la;
  endfunction

  function automatic string band_req(input int fr, input int dp);
    int p;
    if (!m_en) return "R4";
    p = free_pct(fr, dp);
    if (p >= m_thr[2]) return "R8";
    if (p >= m_thr[1]) return "R7";
    if (p >= m_thr[0]) return "R6";
    return "R5";
  endfunction

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_data = 8'(data);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel == 3) m_en = data[7];
    else if (data <= 100) m_thr[sel] = data;
  endtask

  task automatic set_in(input int la, input int fr, input int dp);
    @(negedge clk);
    prog_la = 8'(la); fifo_free = 8'(fr); fifo_depth = 8'(dp);
    #5;
  endtask

  task automatic check_eff(input int la, input int fr, input int dp);
    set_in(la, fr, dp);
    check(band_req(fr, dp), int'(eff_la), exp_eff(la, fr, dp));
  endtask

  task automatic check_abs();
    check("R3 low",  int'(thr_abs_lo),  (m_thr[0] * int'(prog_la)) / 100);
    check("R3 mid",  int'(thr_abs_mid), (m_thr[1] * int'(prog_la)) / 100);
    check("R3 high", int'(thr_abs_hi),  (m_thr[2] * int'(prog_la)) / 100);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int e;
    void'($urandom(32'd4711));
    prog_la = 8'd90; fifo_free = 8'd50; fifo_depth = 8'd100;
    #35 rst_n = 1'b1;
    #2;
    // R1: reset state
    check("R1 eff", int'(eff_la), 90);
    check("R1 abs", int'(thr_abs_lo) + int'(thr_abs_mid) + int'(thr_abs_hi), 0);
    check("R1 count", int'(la_count), 0);
    check("R1 expired", int'(la_expired), 0);

    // thresholds 20/50/80, scaling still off: R4
    wr(0, 20); wr(1, 50); wr(2, 80);
    check_eff(200, 90, 100);
    wr(3, 8'h80);
    // band edges, depth 100
    check_eff(200, 10, 100);   // R5
    check_eff(200, 19, 100);   // R5
    check_eff(200, 20, 100);   // R6 inclusive
    check_eff(201, 49, 100);   // R6
    check_eff(201, 50, 100);   // R7 inclusive
    check_eff(201, 79, 100);   // R7
    check_eff(201, 80, 100);   // R8 inclusive
    check_eff(201, 100, 100);  // R8
    // depth 40: 8 free is exactly 20 %
    check_eff(120, 7, 40);     // R5
    check_eff(120, 8, 40);     // R6
    check_eff(120, 20, 40);    // R7
    check_eff(120, 32, 40);    // R8
    // R3 absolute thresholds with prog 201
    set_in(201, 10, 100);
    check_abs();
    // R2: rejected write leaves threshold unchanged
    wr(0, 101);
    set_in(201, 10, 100);
    check("R2 reject", int'(thr_abs_lo), 40);
    wr(2, 255);
    set_in(201, 10, 100);
    check("R2 reject high", int'(thr_abs_hi), 160);
    wr(2, 100);
    set_in(201, 10, 100);
    check("R2 accept 100", int'(thr_abs_hi), 201);
    check_eff(201, 99, 100);   // R7 with high at 100
    // R8 overlap: mid above high, high wins
    wr(1, 90); wr(2, 30);
    check_eff(200, 40, 100);   // R8
    wr(1, 50); wr(2, 80);
    // R4: scaling off again
    wr(3, 8'h7F);
    check_eff(200, 100, 100);
    wr(3, 8'h80);

    // R9/R10 countdown: eff = 200>>1 = 100 at 30 % free
    set_in(200, 30, 100);
    @(negedge clk); head_new = 1'b1;
    @(negedge clk); head_new = 1'b0;
    #5;
    check("R9 load", int'(la_count), 100);
    check("R10 not expired", int'(la_expired), 0);
    @(negedge clk); tick = 1'b1;
    for (int k = 0; k < 10; k++) @(negedge clk);
    tick = 1'b0;
    #5;
    check("R10 decrement", int'(la_count), 90);
    @(negedge clk); @(negedge clk);
    #5;
    check("R10 hold without tick", int'(la_count), 90);
    // reload mid-count with eff = 200>>2 = 50
    set_in(200, 60, 100);
    @(negedge clk); head_new = 1'b1;
    @(negedge clk); head_new = 1'b0;
    #5;
    check("R9 reload", int'(la_count), 50);
    @(negedge clk); tick = 1'b1;
    for (int k = 0; k < 55; k++) @(negedge clk);
    tick = 1'b0;
    #5;
    check("R10 floor", int'(la_count), 0);
    check("R10 expired", int'(la_expired), 1);
    // zero allowance loads and expires at once
    set_in(200, 90, 100);
    @(negedge clk); head_new = 1'b1;
    @(negedge clk); head_new = 1'b0;
    #5;
    check("R9 zero load", int'(la_count), 0);
    check("R10 zero expired", int'(la_expired), 1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int dp, fr, la;
      if (($urandom % 4) == 0) wr($urandom % 4, $urandom % 140 + (($urandom % 2) * 64));
      dp = $urandom % 255 + 1;
      fr = $urandom % (dp + 1);
      la = $urandom % 256;
      check_eff(la, fr, dp);
      if ((it % 8) == 0) check_abs();
    end
    e = 0;
    finish_run();
  end

endmodule